// File: doc/BRIEF.md
# Configuration image checksum restorer

This block pulls a 64-byte configuration image out of a byte-wide storage port, one read at a time, into a local register array. While reading it adds up bytes 0 through 62, modulo 256, and compares that sum with byte 63. A matching image is presented on a flat output bus with a valid flag. A mismatch starts a restore pass. The block walks a built-in default image and compares it with what it just read. It writes back only the addresses whose contents differ. The default's own checksum byte is not stored: it is summed up during that same walk. The block then runs exactly one more full read-and-check pass.

The storage side uses a valid/ready request channel: `req_valid`, `req_write`, `req_addr` and `req_wdata`, with back-pressure on `req_ready`. Read data returns on a response channel, `rsp_valid`, `rsp_data` and `rsp_err`. The block raises `rsp_ready` only while it waits for the answer to its single outstanding read. Once `req_valid` is asserted, the block holds it and all request fields steady until `req_ready` is seen high on a clock edge. A transfer takes place on every edge where valid and ready are both high. Writes receive no response. Control is a single-cycle `start` pulse. Results are a `done` pulse, a 3-bit outcome code and the image valid flag.

Top module: `cfg_image_loader`

## Requirements
- R1: After reset `busy`, `done`, `img_ok` and `req_valid` are low and `status` is 0 (no outcome yet).
- R2: Each load pass issues reads at addresses 0,1,...,63 in ascending order, with at most one read outstanding, so `rsp_ready` and `req_valid` are never high together.
- R3: If the first pass finds that the modulo-256 sum of bytes 0..62 equals byte 63, then `status` becomes 1 and `img_ok` rises. `cfg_image` then holds byte n at bits [8n+7:8n], and no write is issued.
- R4: On a checksum mismatch the block writes only at the addresses where the byte just read differs from the default image. Default byte layout: byte 0 = 0x01 and bytes 1..7 = 0. For channel k in 0..1 the block starts at 8+20k: host ID 0x07, channel configuration 0x83, maximum tags 0x20, reset recovery 0x0A, then 16 per-target bytes of 0xC8. Bytes 48..62 are 0, and byte 63 is the sum of bytes 0..62 (0x69).
- R5: After the restore writes, exactly one more read pass of 64 reads follows. If it checks good, `status` becomes 2 with `img_ok` high.
- R6: If the second pass also fails its checksum, `status` becomes 3 and `img_ok` stays low. No further request follows.
- R7: A read answered with `rsp_err` high ends the operation at once with `status` 4 and `img_ok` low. No write and no further read follow.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_write`, `req_addr` and `req_wdata` hold their values into the next cycle.
- R9: A `start` pulse while `busy` is high is ignored and does not restart the sweep.
- R10: `done` is a one-cycle pulse issued in the same cycle that `status` and `img_ok` take their final values. `busy` is low from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (ignored while busy) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 none, 1 good first pass, 2 good after restore, 3 bad after restore, 4 read error |
| img_ok | output | 1 | `cfg_image` holds a checked image |
| cfg_image | output | 512 | Loaded image, byte n at bits [8n+7:8n] |
| req_valid | output | 1 | Storage request valid |
| req_ready | input | 1 | Storage accepts the request |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | 6 | Byte address |
| req_wdata | output | 8 | Write data |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Block waits for read data |
| rsp_data | input | 8 | Read data |
| rsp_err | input | 1 | Read failed |

## Verification
The hardest outcome to reach is the failed second pass, because the restore writes normally repair the image. The bench's storage model therefore has a stuck address that silently drops writes. The write to that address is lost, the re-read checksum is still wrong, and the block must stop after exactly 128 reads. The bench also corrupts a known set of bytes in an otherwise default image, which sets the exact number of differing addresses the restore must write. The storage model throttles `req_ready` and varies read latency from a shift register, so the request-hold rule is exercised under back-pressure.

// File: rtl/cfg_img_pkg.sv
package cfg_img_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_WAIT,
    S_CHECK,
    S_WRITE
  } ldr_state_e;

  typedef enum logic [2:0] {
    ST_NONE        = 3'd0,
    ST_OK_FIRST    = 3'd1,
    ST_OK_RESTORED = 3'd2,
    ST_BAD         = 3'd3,
    ST_READ_ABORT  = 3'd4
  } ldr_status_e;
endpackage

// File: rtl/cfg_sum_acc.sv
module cfg_sum_acc #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] sum
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sum <= '0;
    else if (clr) sum <= '0;
    else if (en)  sum <= sum + din;
  end
endmodule

// File: rtl/cfg_default_table.sv
module cfg_default_table #(
  parameter int          AW         = 6,
  parameter int          DW         = 8,
  parameter int          HDR_BYTES  = 8,
  parameter int          CHANNELS   = 2,
  parameter int          TARGETS    = 16,
  parameter logic [7:0]  FMT_REV    = 8'h01,
  parameter logic [7:0]  HOST_ID    = 8'h07,
  parameter logic [7:0]  CHAN_CFG   = 8'h83,
  parameter logic [7:0]  MAX_TAGS   = 8'h20,
  parameter logic [7:0]  RST_RECOV  = 8'h0A,
  parameter logic [7:0]  TARGET_CFG = 8'hC8
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] dflt
);
  localparam int CH_FIXED = 4;
  localparam int CH_BYTES = CH_FIXED + TARGETS;

  always_comb begin
    int a;
    int off;
    a    = int'(addr);
    dflt = '0;
    if (a == 0) dflt = DW'(FMT_REV);
    for (int ch = 0; ch < CHANNELS; ch++) begin
      off = a - (HDR_BYTES + ch * CH_BYTES);
      if (off >= 0 && off < CH_BYTES) begin
        case (off)
          0:       dflt = DW'(HOST_ID);
          1:       dflt = DW'(CHAN_CFG);
          2:       dflt = DW'(MAX_TAGS);
          3:       dflt = DW'(RST_RECOV);
          default: dflt = DW'(TARGET_CFG);
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_image_store.sv
module cfg_image_store #(
  parameter int IMG_BYTES = 64,
  parameter int DW        = 8,
  localparam int AW       = $clog2(IMG_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  output logic [IMG_BYTES*DW-1:0] flat
);
  logic [DW-1:0] mem [IMG_BYTES];

  for (genvar g = 0; g < IMG_BYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       mem[g] <= '0;
      else if (we && addr == AW'(g))    mem[g] <= wdata;
    end
    assign flat[g*DW +: DW] = mem[g];
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
  import cfg_img_pkg::*;
#(
  parameter int IMG_BYTES = 64,
  parameter int DW        = 8,
  localparam int AW       = $clog2(IMG_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  output logic [2:0]              status,
  output logic                    img_ok,
  output logic [IMG_BYTES*DW-1:0] cfg_image,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic                    req_write,
  output logic [AW-1:0]           req_addr,
  output logic [DW-1:0]           req_wdata,
  input  logic                    rsp_valid,
  output logic                    rsp_ready,
  input  logic [DW-1:0]           rsp_data,
  input  logic                    rsp_err
);
  localparam logic [AW-1:0] LAST = AW'(IMG_BYTES - 1);

  ldr_state_e    state;
  ldr_status_e   status_q;
  logic [AW-1:0] addr;
  logic          retry_pass;
  logic          done_q;
  logic          img_ok_q;

  logic [DW-1:0] rd_byte, dflt_raw, dflt_byte, rsum, dsum;
  logic          store_we, differs, advance, at_last;
  logic          rsum_clr, rsum_en, dsum_clr, dsum_en;

  assign at_last  = (addr == LAST);
  assign store_we = (state == S_RD_WAIT) && rsp_valid && !rsp_err;
  assign dflt_byte = at_last ? dsum : dflt_raw;
  assign differs  = (dflt_byte != rd_byte);
  assign advance  = (state == S_WRITE) && (!differs || req_ready);

  // read-pass sum: cleared at each pass start, adds bytes below the last
  assign rsum_clr = (state == S_IDLE && start) || (advance && at_last);
  assign rsum_en  = store_we && !at_last;
  // default-image sum built up during the restore walk
  assign dsum_clr = (state == S_CHECK);
  assign dsum_en  = advance && !at_last;

  cfg_image_store #(.IMG_BYTES(IMG_BYTES), .DW(DW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (store_we),
    .addr  (addr),
    .wdata (rsp_data),
    .rdata (rd_byte),
    .flat  (cfg_image)
  );

  cfg_default_table #(.AW(AW), .DW(DW)) u_dflt (
    .addr (addr),
    .dflt (dflt_raw)
  );

  cfg_sum_acc #(.DW(DW)) u_rsum (
    .clk (clk), .rst_n (rst_n), .clr (rsum_clr), .en (rsum_en),
    .din (rsp_data), .sum (rsum)
  );

  cfg_sum_acc #(.DW(DW)) u_dsum (
    .clk (clk), .rst_n (rst_n), .clr (dsum_clr), .en (dsum_en),
    .din (dflt_raw), .sum (dsum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      status_q   <= ST_NONE;
      addr       <= '0;
      retry_pass <= 1'b0;
      done_q     <= 1'b0;
      img_ok_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            state      <= S_RD_REQ;
            addr       <= '0;
            retry_pass <= 1'b0;
            img_ok_q   <= 1'b0;
            status_q   <= ST_NONE;
          end
        end
        S_RD_REQ: begin
          if (req_ready) state <= S_RD_WAIT;
        end
        S_RD_WAIT: begin
          if (rsp_valid) begin
            if (rsp_err) begin
              status_q <= ST_READ_ABORT;
              done_q   <= 1'b1;
              state    <= S_IDLE;
            end else if (at_last) begin
              state <= S_CHECK;
            end else begin
              addr  <= addr + 1'b1;
              state <= S_RD_REQ;
            end
          end
        end
        S_CHECK: begin
          if (rsum == rd_byte) begin
            status_q <= retry_pass ? ST_OK_RESTORED : ST_OK_FIRST;
            img_ok_q <= 1'b1;
            done_q   <= 1'b1;
            state    <= S_IDLE;
          end else if (retry_pass) begin
            status_q <= ST_BAD;
            done_q   <= 1'b1;
            state    <= S_IDLE;
          end else begin
            addr  <= '0;
            state <= S_WRITE;
          end
        end
        S_WRITE: begin
          if (advance) begin
            if (at_last) begin
              retry_pass <= 1'b1;
              addr       <= '0;
              state      <= S_RD_REQ;
            end else begin
              addr <= addr + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = done_q;
  assign status    = status_q;
  assign img_ok    = img_ok_q;
  assign req_valid = (state == S_RD_REQ) || ((state == S_WRITE) && differs);
  assign req_write = (state == S_WRITE);
  assign req_addr  = addr;
  assign req_wdata = (state == S_WRITE) ? dflt_byte : '0;
  assign rsp_ready = (state == S_RD_WAIT);
endmodule

// File: rtl/cfg_image_loader_chk.sv
module cfg_image_loader_chk #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [2:0]    status,
  input logic          img_ok,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic          rsp_ready
);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
      && $stable(req_write) && $stable(req_wdata)));

  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_ok_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    img_ok |-> (status == 3'd1 || status == 3'd2));

  assert_abort_no_image_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd4) |-> !img_ok);

  assert_bad_no_image_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd3) |-> !img_ok);
endmodule

bind cfg_image_loader cfg_image_loader_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .status    (status),
  .img_ok    (img_ok),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_ready (rsp_ready)
);

// File: tb/cfg_image_loader_tb.sv
`timescale 1ns/1ps
module cfg_image_loader_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         busy, done, img_ok;
  logic [2:0]   status;
  logic [511:0] cfg_image;
  logic         req_valid, req_write, rsp_ready;
  logic         req_ready = 1'b1;
  logic [5:0]   req_addr;
  logic [7:0]   req_wdata;
  logic         rsp_valid = 1'b0;
  logic [7:0]   rsp_data = '0;
  logic         rsp_err = 1'b0;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cfg_image_loader u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .status(status), .img_ok(img_ok), .cfg_image(cfg_image),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  // storage model
  logic [7:0] mem [64];
  int         stuck_addr = -1;
  int         err_addr = -1;
  bit         bp_en = 1'b0;
  int         rd_cnt = 0, wr_cnt = 0, order_bad = 0, hold_bad = 0, done_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic       pend = 1'b0;
  logic [5:0] pend_addr = '0;
  logic [1:0] lat = '0;
  logic [5:0] nxt_rd = '0;
  logic       prev_stall = 1'b0;
  logic [5:0] prev_addr = '0;
  logic [7:0] prev_wdata = '0;
  logic       prev_write = 1'b0;

  always @(posedge clk) begin
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    req_ready <= bp_en ? lfsr[0] : 1'b1;
    if (done) done_cnt <= done_cnt + 1;
    // request hold check (R8)
    if (prev_stall && (!req_valid || req_addr != prev_addr ||
        req_wdata != prev_wdata || req_write != prev_write))
      hold_bad <= hold_bad + 1;
    prev_stall <= req_valid && !req_ready;
    prev_addr  <= req_addr;
    prev_wdata <= req_wdata;
    prev_write <= req_write;
    if (req_valid && req_ready) begin
      if (req_write) begin
        wr_cnt <= wr_cnt + 1;
        if (int'(req_addr) != stuck_addr) mem[req_addr] <= req_wdata;
      end else begin
        if (req_addr != 6'd0 && req_addr != nxt_rd) order_bad <= order_bad + 1;
        nxt_rd    <= req_addr + 6'd1;
        rd_cnt    <= rd_cnt + 1;
        pend      <= 1'b1;
        pend_addr <= req_addr;
        lat       <= bp_en ? lfsr[2:1] : 2'd0;
      end
    end
    if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
    if (pend && !rsp_valid) begin
      if (lat == 0) begin
        rsp_valid <= 1'b1;
        rsp_data  <= mem[pend_addr];
        rsp_err   <= (int'(pend_addr) == err_addr);
        pend      <= 1'b0;
      end else lat <= lat - 2'd1;
    end
  end

  // independent model of the default image (R4 layout)
  function automatic logic [7:0] dflt_byte(int a);
    int s;
    if (a == 63) begin
      s = 0;
      for (int i = 0; i < 63; i++) s += int'(dflt_byte(i));
      return 8'(s);
    end
    if (a == 0) return 8'h01;
    for (int ch = 0; ch < 2; ch++) begin
      if (a == 8 + 20*ch)     return 8'h07;
      if (a == 9 + 20*ch)     return 8'h83;
      if (a == 10 + 20*ch)    return 8'h20;
      if (a == 11 + 20*ch)    return 8'h0A;
      if (a >= 12 + 20*ch && a < 28 + 20*ch) return 8'hC8;
    end
    return 8'h00;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_and_wait(output bit timed_out);
    timed_out = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (done) return;
      @(negedge clk);
    end
    timed_out = 1'b1;
    check(1'b0, "R10", "done timeout", 0, 1);
  endtask

  task automatic check_image(string req);
    int bad = 0;
    for (int i = 0; i < 64; i++)
      if (cfg_image[i*8 +: 8] != mem[i]) bad++;
    check(bad == 0, req, "image bytes mismatching", bad, 0);
  endtask

  task automatic t_reset();
    check(!busy && !done && !img_ok && !req_valid, "R1", "idle outputs",
          {busy, done, img_ok, req_valid}, 0);
    check(status == 3'd0, "R1", "status after reset", status, 0);
  endtask

  task automatic t_good_first();
    int s = 0, r0, w0;
    bit to;
    for (int i = 0; i < 63; i++) begin
      mem[i] = 8'(i * 37 + 5);
      s += int'(mem[i]);
    end
    mem[63] = 8'(s);
    r0 = rd_cnt; w0 = wr_cnt;
    run_and_wait(to);
    check(status == 3'd1, "R3", "status good image", status, 1);
    check(img_ok, "R3", "img_ok", img_ok, 1);
    check(!busy, "R10", "busy at done", busy, 0);
    check_image("R3");
    check(rd_cnt - r0 == 64, "R2", "read count", rd_cnt - r0, 64);
    check(wr_cnt == w0, "R3", "writes on good image", wr_cnt - w0, 0);
  endtask

  task automatic corrupt_default();
    for (int i = 0; i < 64; i++) mem[i] = dflt_byte(i);
    mem[3]  = 8'h11;
    mem[12] = 8'h00;
    mem[40] = 8'hC9;
    mem[63] = 8'h00;
  endtask

  task automatic t_restore_ok();
    int r0, w0, bad = 0;
    bit to;
    corrupt_default();
    bp_en = 1'b1;
    r0 = rd_cnt; w0 = wr_cnt;
    run_and_wait(to);
    check(status == 3'd2, "R5", "status after restore", status, 2);
    check(img_ok, "R5", "img_ok after restore", img_ok, 1);
    check(wr_cnt - w0 == 4, "R4", "differing writes", wr_cnt - w0, 4);
    check(rd_cnt - r0 == 128, "R5", "reads over two passes", rd_cnt - r0, 128);
    for (int i = 0; i < 64; i++) if (mem[i] != dflt_byte(i)) bad++;
    check(bad == 0, "R4", "storage equals default", bad, 0);
    check(mem[63] == 8'h69, "R4", "default checksum byte", mem[63], 8'h69);
    check_image("R5");
    check(hold_bad == 0, "R8", "request hold violations", hold_bad, 0);
    bp_en = 1'b0;
  endtask

  task automatic t_restore_bad();
    int r0, w0, d0;
    bit to;
    corrupt_default();
    stuck_addr = 12;
    r0 = rd_cnt; w0 = wr_cnt;
    run_and_wait(to);
    check(status == 3'd3, "R6", "status restore failed", status, 3);
    check(!img_ok, "R6", "img_ok low", img_ok, 0);
    d0 = rd_cnt + wr_cnt;
    repeat (30) @(negedge clk);
    check(rd_cnt + wr_cnt == d0, "R6", "traffic after done", rd_cnt + wr_cnt - d0, 0);
    check(rd_cnt - r0 == 128, "R6", "single retry reads", rd_cnt - r0, 128);
    check(wr_cnt - w0 == 4, "R4", "writes with stuck byte", wr_cnt - w0, 4);
    stuck_addr = -1;
  endtask

  task automatic t_read_err();
    int r0, w0;
    bit to;
    corrupt_default();
    err_addr = 10;
    r0 = rd_cnt; w0 = wr_cnt;
    run_and_wait(to);
    check(status == 3'd4, "R7", "status read error", status, 4);
    check(!img_ok, "R7", "img_ok low", img_ok, 0);
    repeat (20) @(negedge clk);
    check(rd_cnt - r0 == 11, "R7", "reads up to error", rd_cnt - r0, 11);
    check(wr_cnt == w0, "R7", "writes after error", wr_cnt - w0, 0);
    err_addr = -1;
  endtask

  task automatic t_start_busy();
    int s = 0, r0, d0;
    for (int i = 0; i < 63; i++) begin
      mem[i] = 8'(i ^ 8'h5A);
      s += int'(mem[i]);
    end
    mem[63] = 8'(s);
    r0 = rd_cnt; d0 = done_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (400) @(negedge clk);
    check(done_cnt - d0 == 1, "R9", "done pulses", done_cnt - d0, 1);
    check(rd_cnt - r0 == 64, "R9", "reads with extra start", rd_cnt - r0, 64);
    check(status == 3'd1, "R9", "status", status, 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good_first();
    t_restore_ok();
    t_restore_bad();
    t_read_err();
    t_start_busy();
    check(order_bad == 0, "R2", "ascending read order", order_bad, 0);
    check(hold_bad == 0, "R8", "request hold overall", hold_bad, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #900000;
    n_checks++;
    n_fail++;
    $display("FAIL R10 watchdog: actual %0d expected %0d", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule